// File: doc/BRIEF.md
# Daisy-Chained System Bus Arbiter

This block decides which of several processors may drive a single shared system bus. Every processor has its own arbitration cell. The cells are linked in a priority chain. A cell that is enabled from upstream and has no request of its own passes the enable on to the next cell. A cell that is enabled and is requesting stops the enable and becomes the selected cell. The selected cell takes the bus only when the shared busy line is idle. Once it holds the bus, it keeps the bus for as long as its processor keeps requesting. A processor that has higher priority never interrupts a transfer that is already running. It waits until the busy line drops and then competes again.

The chain works in one of two orderings, chosen by a mode input. In fixed ordering, cell 0 always sits at the head of the chain. In ring ordering, the end of the chain wraps back to its start. The chain is cut just after the cell that most recently owned the bus, so the search for a new owner begins at the next cell. Cutting the ring at that point keeps the combinational chain free of loops. After reset, the first search in ring ordering starts at cell 0.

A grant is registered. It appears one clock after the request that wins it, and it stays asserted until the clock after the owner lowers its request.

Top module: `dcarb_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, all grant bits and the busy output are 0.
- R2: When the bus is idle and at least one request is high at a rising clock edge, busy and exactly one grant bit are set after that edge. The granted bit is one whose request was high. In fixed ordering (mode input 0), it is the lowest-numbered requesting cell.
- R3: At most one grant bit is high in any cycle. A grant bit is high exactly when the busy output is high.
- R4: While the owner's request stays high, the grant does not change, whatever the other request bits do. Higher-priority requests do not pre-empt the owner.
- R5: At the first rising edge where the owner's request is low, grant and busy clear. A waiting cell can acquire the bus at the next edge at the earliest, so there is exactly one idle cycle between owners.
- R6: In ring ordering (mode input 1), the search for a new owner starts at cell (last owner + 1) mod N and proceeds upward, wrapping from N-1 to 0. The first requesting cell found wins.
- R7: After reset, the last-owner position is N-1, so the first acquisition in ring ordering favours cell 0.
- R8: With no request high and the bus idle, the bus stays idle and no grant is given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| ring_mode_i | input | 1 | 0: fixed ordering with cell 0 at the head; 1: ring ordering that follows the last owner |
| req_i | input | NCELL | One bus request per processor; bit i belongs to cell i |
| grant_o | output | NCELL | One-hot grant; bit i means cell i owns the bus |
| busy_o | output | 1 | Shared busy line, high while any cell owns the bus |

## Verification
A corrupted owner register shows up at the ports on the very next clock. The grant either moves without a falling request, or it fails to fall one edge after the owner lets go. A head pointer that is off by one is invisible in fixed ordering. In ring ordering it shows within one hand-over, because a cell other than the first requester after the last owner receives the bus. A cycle-by-cycle reference model in the bench compares every grant and busy value under directed hand-over sequences and under long streams of random requests in both orderings.

// File: rtl/dcarb_pkg.sv
package dcarb_pkg;

  typedef enum logic {
    BUS_IDLE  = 1'b0,
    BUS_OWNED = 1'b1
  } bus_state_e;

  // modular step around the ring of n cells
  function automatic int unsigned ring_add(int unsigned a, int unsigned b, int unsigned n);
    return (a + b) % n;
  endfunction

endpackage

// File: rtl/dcarb_cell.sv
module dcarb_cell (
  input  logic pi,
  input  logic req,
  output logic po,
  output logic sel
);
  // enable passes on only past an idle cell; an enabled requester keeps it
  assign po  = pi & ~req;
  assign sel = pi & req;
endmodule

// File: rtl/dcarb_chain.sv
module dcarb_chain #(
  parameter int NCELL = 4,
  localparam int IW = (NCELL > 1) ? $clog2(NCELL) : 1
) (
  input  logic [NCELL-1:0] req,
  input  logic [IW-1:0]    head,
  output logic [NCELL-1:0] sel,
  output logic             none
);
  import dcarb_pkg::*;

  logic [NCELL-1:0] req_pos;
  logic [NCELL-1:0] sel_pos;
  logic [NCELL:0]   link;

  // position p of the chain is cell (head + p) mod NCELL; chain is cut before head
  always_comb begin
    for (int p = 0; p < NCELL; p++) begin
      req_pos[p] = req[IW'(ring_add(32'(head), unsigned'(p), NCELL))];
    end
  end

  assign link[0] = 1'b1;

  generate
    for (genvar p = 0; p < NCELL; p++) begin : g_cell
      dcarb_cell u_cell (
        .pi  (link[p]),
        .req (req_pos[p]),
        .po  (link[p+1]),
        .sel (sel_pos[p])
      );
    end
  endgenerate

  // enable surviving the whole chain means nobody asked
  assign none = link[NCELL];

  always_comb begin
    sel = '0;
    for (int p = 0; p < NCELL; p++) begin
      sel[IW'(ring_add(32'(head), unsigned'(p), NCELL))] = sel_pos[p];
    end
  end
endmodule

// File: rtl/dcarb_owner.sv
module dcarb_owner #(
  parameter int NCELL = 4,
  localparam int IW = (NCELL > 1) ? $clog2(NCELL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NCELL-1:0] req,
  input  logic [NCELL-1:0] sel,
  input  logic             none,
  output logic [NCELL-1:0] grant,
  output logic             busy,
  output logic [IW-1:0]    owner_idx,
  output logic             take,
  output logic             drop
);
  import dcarb_pkg::*;

  bus_state_e    state_q;
  logic [IW-1:0] owner_q;
  logic [IW-1:0] sel_idx;

  always_comb begin
    sel_idx = '0;
    for (int i = 0; i < NCELL; i++) begin
      if (sel[i]) sel_idx = IW'(i);
    end
  end

  assign take = (state_q == BUS_IDLE) && !none;
  assign drop = (state_q == BUS_OWNED) && !req[owner_q];

  // owner_q doubles as the last-owner position once the bus is released
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= BUS_IDLE;
      owner_q <= IW'(NCELL - 1);
    end else if (take) begin
      state_q <= BUS_OWNED;
      owner_q <= sel_idx;
    end else if (drop) begin
      state_q <= BUS_IDLE;
    end
  end

  assign busy      = (state_q == BUS_OWNED);
  assign grant     = busy ? (NCELL'(1) << owner_q) : '0;
  assign owner_idx = owner_q;
endmodule

// File: rtl/dcarb_top.sv
module dcarb_top #(
  parameter int NCELL = 4,
  localparam int IW = (NCELL > 1) ? $clog2(NCELL) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ring_mode_i,
  input  logic [NCELL-1:0] req_i,
  output logic [NCELL-1:0] grant_o,
  output logic             busy_o
);
  import dcarb_pkg::*;

  logic [NCELL-1:0] sel_w;
  logic             none_w;
  logic [IW-1:0]    owner_w;
  logic [IW-1:0]    head_w;
  logic             take_w;
  logic             drop_w;

  // ring ordering opens the chain just after the latest owner
  assign head_w = ring_mode_i ? IW'(ring_add(32'(owner_w), 1, NCELL)) : '0;

  dcarb_chain #(.NCELL(NCELL)) u_chain (
    .req  (req_i),
    .head (head_w),
    .sel  (sel_w),
    .none (none_w)
  );

  dcarb_owner #(.NCELL(NCELL)) u_owner (
    .clk       (clk),
    .rst_n     (rst_n),
    .req       (req_i),
    .sel       (sel_w),
    .none      (none_w),
    .grant     (grant_o),
    .busy      (busy_o),
    .owner_idx (owner_w),
    .take      (take_w),
    .drop      (drop_w)
  );
endmodule

// File: rtl/dcarb_chk.sv
module dcarb_chk #(
  parameter int NCELL = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [NCELL-1:0] req_i,
  input logic [NCELL-1:0] grant_o,
  input logic             busy_o,
  input logic [NCELL-1:0] sel_w,
  input logic             take_w,
  input logic             drop_w
);
  p_grant_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));

  p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel_w));

  p_grant_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant_o) == busy_o);

  p_take_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    take_w |-> !busy_o);

  p_sel_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_w & ~req_i) == '0);

  p_acquire_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && (|req_i)) |=> (busy_o && ((grant_o & ~$past(req_i)) == '0)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|(grant_o & req_i)) |=> (grant_o == $past(grant_o)));

  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !(|(grant_o & req_i))) |=> (!busy_o && grant_o == '0));

  p_drop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drop_w |=> !busy_o);

  p_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && !(|req_i)) |=> !busy_o);
endmodule

bind dcarb_top dcarb_chk #(.NCELL(NCELL)) chk_i (
  .clk     (clk),
  .rst_n   (rst_n),
  .req_i   (req_i),
  .grant_o (grant_o),
  .busy_o  (busy_o),
  .sel_w   (sel_w),
  .take_w  (take_w),
  .drop_w  (drop_w)
);

// File: tb/dcarb_top_tb_top.sv
module dcarb_top_tb_top;
  localparam int  NCELL = 4;
  localparam time CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             ring = 1'b0;
  logic [NCELL-1:0] req = '0;
  logic [NCELL-1:0] grant;
  logic             busy;

  int n_chk = 0;
  int n_fail = 0;

  // reference state, kept independently of the design
  bit m_busy;
  int m_owner;

  logic [NCELL-1:0] exp_grant_q[$];
  bit               exp_busy_q[$];
  string            tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  dcarb_top #(.NCELL(NCELL)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .ring_mode_i (ring),
    .req_i       (req),
    .grant_o     (grant),
    .busy_o      (busy)
  );

  task automatic check(input string tag, input logic [NCELL-1:0] g_exp, input bit b_exp);
    n_chk++;
    if (grant !== g_exp || busy !== b_exp) begin
      n_fail++;
      $display("FAIL %s grant=%b busy=%b expected grant=%b busy=%b", tag, grant, busy, g_exp, b_exp);
    end
  endtask

  // advance the reference by one edge using the inputs now applied
  task automatic model_step();
    if (m_busy) begin
      if (!req[m_owner]) m_busy = 0;
    end else begin
      int start;
      start = ring ? (m_owner + 1) % NCELL : 0;
      for (int k = 0; k < NCELL; k++) begin
        int c;
        c = (start + k) % NCELL;
        if (!m_busy && req[c]) begin
          m_busy  = 1;
          m_owner = c;
        end
      end
    end
  endtask

  // driver: apply a request pattern for one cycle and queue the expected result
  task automatic cyc(input logic [NCELL-1:0] r, input string tag);
    req = r;
    model_step();
    exp_grant_q.push_back(m_busy ? (NCELL'(1) << m_owner) : '0);
    exp_busy_q.push_back(m_busy);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic do_reset(input bit mode);
    rst_n = 1'b0;
    req   = '0;
    ring  = mode;
    repeat (2) @(negedge clk);
    check("R1 during reset", '0, 1'b0);
    m_busy  = 0;
    m_owner = NCELL - 1;
    rst_n   = 1'b1;
    @(negedge clk);
    check("R1 after reset", '0, 1'b0);
  endtask

  // monitor: compare away from the active edge
  initial begin
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (exp_grant_q.size() > 0) begin
        logic [NCELL-1:0] g;
        bit b;
        string t;
        g = exp_grant_q.pop_front();
        b = exp_busy_q.pop_front();
        t = tag_q.pop_front();
        check(t, g, b);
        n_chk++;
        if ($countones(grant) > 1) begin
          n_fail++;
          $display("FAIL R3 grant=%b expected at most one bit", grant);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [NCELL-1:0] cur;
    @(negedge clk);
    do_reset(1'b0);

    // R8: idle with no requests
    repeat (3) cyc(4'b0000, "R8 idle");

    // R2: fixed ordering picks the lowest index
    cyc(4'b0110, "R2 acquire low index");
    cyc(4'b0110, "R2 hold");
    // R4: cell 0 asks while cell 1 owns
    cyc(4'b0111, "R4 no preempt");
    cyc(4'b0101, "R5 release");
    cyc(4'b0101, "R5 next owner");
    cyc(4'b0100, "R5 release again");
    cyc(4'b0100, "R2 single requester");
    cyc(4'b1100, "R4 hold with other request");
    cyc(4'b1000, "R5 drop");
    cyc(4'b1000, "R2 high index");
    cyc(4'b0000, "R5 drop to idle");
    cyc(4'b0000, "R8 idle again");

    // R7 and R6: ring ordering
    do_reset(1'b1);
    cyc(4'b1111, "R7 ring starts at cell 0");
    cyc(4'b1110, "R5 ring release");
    cyc(4'b1111, "R6 next after cell 0");
    cyc(4'b1101, "R5 ring release");
    cyc(4'b1011, "R6 skip idle cell 2");
    cyc(4'b0011, "R5 ring release");
    cyc(4'b0011, "R6 wrap to cell 0");
    cyc(4'b0010, "R5 ring release");
    cyc(4'b1010, "R6 cell 1 after 0");
    cyc(4'b1000, "R5 ring release");
    cyc(4'b1001, "R6 cell 3 after 1");
    cyc(4'b0001, "R5 ring release");
    cyc(4'b0001, "R6 wrap to 0");

    // random traffic in both orderings
    cur = '0;
    for (int m = 0; m < 2; m++) begin
      ring = (m == 1);
      for (int i = 0; i < 400; i++) begin
        if (($urandom % 4) == 0) cur = NCELL'($urandom);
        cyc(cur, (m == 1) ? "R6 random ring" : "R3 random fixed");
      end
    end

    cyc(4'b0000, "R5 final drop");
    cyc(4'b0000, "R8 final idle");
    @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule